// File: doc/BRIEF.md
# Byte FIFO Pair with Level Thresholds

This block sits between a register bus and a serial shifter. It holds two byte queues. The transmit queue is filled from the bus and drained one byte at a time by the shifter. The receive queue is filled one byte at a time by the shifter and drained from the bus. A bus access moves one, two or four bytes in a single cycle, and the lowest byte lane comes first in queue order.

Each queue keeps a byte count that is visible at the ports. Each count is compared with a programmable level, and the two comparisons point opposite ways. The transmit side asks for more data while it is running low. The receive side asks to be drained once it holds more than its level. These comparisons drive one DMA request line per direction, each gated by its own enable.

A set of sticky status flags records threshold, empty or full, and the four error cases: a bus write that does not fit, a shifter pop of an empty queue, a shifter push into a full queue, and a bus read of more bytes than are stored. Flags are cleared by writing ones. A masked, registered interrupt line summarises them. Each queue can be disabled on its shifter side, or emptied at once with a clear pulse.

Top module: `byte_fifo_pair`

## Requirements
- R1: A bus write (busWrEn) with busSize 2'b00, 2'b01, or 2'b10/2'b11 pushes 1, 2 or 4 bytes into the transmit queue. busWrData[7:0] is queued first, then [15:8], and so on. The shifter pops the bytes in that order on shTxData, in the cycle it asserts shTxPop.
- R2: A bus read (busRdEn) with the same size encoding pops 1, 2 or 4 bytes from the receive queue within that cycle. The oldest byte appears on busRdData[7:0], the next bytes fill the higher lanes, and unused upper lanes read zero.
- R3: txCount and rxCount equal the bytes stored, 0 after reset. They never exceed the depths: 16 for transmit (5-bit count) and 32 for receive (6-bit count).
- R4: txDmaReq is high while txDmaEn is set and txCount < txLevel. The transmit-threshold flag, flags[0], is set one cycle after txCount < txLevel is true.
- R5: rxDmaReq is high while rxDmaEn is set and rxCount > rxLevel. The receive-threshold flag, flags[2], is set one cycle after rxCount > rxLevel is true.
- R6: Clearing a DMA enable drops that direction's request in the same cycle, with no clock edge in between.
- R7: A bus write whose bytes do not all fit is dropped whole, leaving the transmit contents unchanged, and sets flags[4].
- R8: A shifter pop of an empty, enabled transmit queue returns 0 on shTxData and sets flags[5].
- R9: A shifter push into a full, enabled receive queue is dropped and sets flags[6].
- R10: A bus read of more bytes than rxCount pops nothing, returns 0, and sets flags[7].
- R11: All flags are sticky until a 1 is written to that bit of flagClr. flags[1] records an empty transmit queue and flags[3] a full receive queue.
- R12: A txClr or rxClr pulse empties that queue. It clears that queue's flags (transmit 0,1,4,5; receive 2,3,6,7) and leaves the other queue's flags alone.
- R13: irq is high one cycle after any flag bit is set whose irqEn bit is set, and is low while no enabled flag is set.
- R14: With txEn low, shifter pops are ignored and shTxData reads 0. With rxEn low, shifter pushes are ignored. Bus-side accesses are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busWrEn | input | 1 | Bus write strobe for the transmit queue |
| busRdEn | input | 1 | Bus read strobe for the receive queue |
| busSize | input | 2 | Access width: 00 byte, 01 half, 1x word |
| busWrData | input | 32 | Bus write data |
| busRdData | output | 32 | Bus read data, valid in the read cycle |
| shTxPop | input | 1 | Shifter pops one transmit byte |
| shTxData | output | 8 | Popped transmit byte, valid in the pop cycle |
| shRxPush | input | 1 | Shifter pushes one receive byte |
| shRxData | input | 8 | Byte pushed by the shifter |
| txEn | input | 1 | Enables the shifter side of the transmit queue |
| rxEn | input | 1 | Enables the shifter side of the receive queue |
| txClr | input | 1 | Empties the transmit queue and its flags |
| rxClr | input | 1 | Empties the receive queue and its flags |
| txLevel | input | 5 | Transmit low-water level |
| rxLevel | input | 6 | Receive high-water level |
| txDmaEn | input | 1 | Transmit DMA request enable |
| rxDmaEn | input | 1 | Receive DMA request enable |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |
| txCount | output | 5 | Bytes in the transmit queue |
| rxCount | output | 6 | Bytes in the receive queue |
| flagClr | input | 8 | Write-one-to-clear strobes for the flags |
| irqEn | input | 8 | Per-flag interrupt enables |
| flags | output | 8 | Sticky status flags |
| irq | output | 1 | Registered interrupt |

## Verification
The bench fills the transmit queue to exactly 16 bytes and then offers one more byte. A design that accepted a partial write, or wrapped the pointer, would lose or reorder bytes, and the 16 popped bytes would not match the scoreboard. It reads a word while only one byte is stored: a design that popped that byte anyway would return it and then give wrong data on the next read. It fills the receive queue to 32 bytes and then pushes once more. It checks the threshold comparisons at exactly level and level plus one, where an off-by-one design would raise or hold the DMA request at the wrong count. It clears one queue and checks that the other queue's flags survive.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;

  localparam int FLAG_W = 8;

  // flag bit positions
  localparam int F_TX_THR   = 0;
  localparam int F_TX_EMPTY = 1;
  localparam int F_RX_THR   = 2;
  localparam int F_RX_FULL  = 3;
  localparam int F_TX_OVR   = 4;
  localparam int F_TX_UND   = 5;
  localparam int F_RX_OVR   = 6;
  localparam int F_RX_UND   = 7;

  localparam logic [FLAG_W-1:0] TX_FLAG_MASK = 8'h33;
  localparam logic [FLAG_W-1:0] RX_FLAG_MASK = 8'hCC;

  // strobes from control to datapath
  typedef struct packed {
    logic [2:0] txPushN;
    logic       txPop;
    logic       rxPush;
    logic [2:0] rxPopN;
    logic       txClr;
    logic       rxClr;
  } fifo_strobe_t;

  function automatic logic [2:0] sizeToBytes(input logic [1:0] size);
    case (size)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 32,
  parameter int LANES = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           clr,
  input  logic [2:0]                     pushN,
  input  logic [LANES*8-1:0]             pushData,
  input  logic [2:0]                     popN,
  output logic [LANES*8-1:0]             peek,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(pushN);
      rdPtr <= rdPtr + AW'(popN);
      count <= count + CW'(pushN) - CW'(popN);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (!clr && (3'(i) < pushN)) begin
        mem[wrPtr + AW'(i)] <= pushData[8*i +: 8];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      peek[8*i +: 8] = mem[rdPtr + AW'(i)];
    end
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (pushN != 3'd0) |-> ((CW+1)'(count) + (CW+1)'(pushN) <= (CW+1)'(DEPTH)));

  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (popN != 3'd0) |-> (CW'(popN) <= count));

  a_r12_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (count == '0));

endmodule

// File: rtl/fifo_pair_datapath.sv
module fifo_pair_datapath
  import fifo_pair_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  fifo_strobe_t                      strobe,
  input  logic [31:0]                       busWrData,
  input  logic [7:0]                        shRxData,
  output logic [31:0]                       busRdData,
  output logic [7:0]                        shTxData,
  output logic [$clog2(TX_DEPTH+1)-1:0]     txCount,
  output logic [$clog2(RX_DEPTH+1)-1:0]     rxCount
);
  logic [31:0] txPeek;
  logic [31:0] rxPeek;

  byte_fifo #(.DEPTH(TX_DEPTH), .LANES(4)) u_txFifo (
    .clk      (clk),
    .rstN     (rstN),
    .clr      (strobe.txClr),
    .pushN    (strobe.txPushN),
    .pushData (busWrData),
    .popN     ({2'b00, strobe.txPop}),
    .peek     (txPeek),
    .count    (txCount)
  );

  byte_fifo #(.DEPTH(RX_DEPTH), .LANES(4)) u_rxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .clr      (strobe.rxClr),
    .pushN    ({2'b00, strobe.rxPush}),
    .pushData ({24'h0, shRxData}),
    .popN     (strobe.rxPopN),
    .peek     (rxPeek),
    .count    (rxCount)
  );

  // only lanes actually popped are driven; the rest read zero
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      busRdData[8*i +: 8] = (3'(i) < strobe.rxPopN) ? rxPeek[8*i +: 8] : 8'h00;
    end
  end

  assign shTxData = strobe.txPop ? txPeek[7:0] : 8'h00;

endmodule

// File: rtl/fifo_pair_ctrl.sv
module fifo_pair_ctrl
  import fifo_pair_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busWrEn,
  input  logic                              busRdEn,
  input  logic [1:0]                        busSize,
  input  logic                              shTxPop,
  input  logic                              shRxPush,
  input  logic                              txEn,
  input  logic                              rxEn,
  input  logic                              txClr,
  input  logic                              rxClr,
  input  logic [$clog2(TX_DEPTH+1)-1:0]     txLevel,
  input  logic [$clog2(RX_DEPTH+1)-1:0]     rxLevel,
  input  logic                              txDmaEn,
  input  logic                              rxDmaEn,
  input  logic [FLAG_W-1:0]                 flagClr,
  input  logic [FLAG_W-1:0]                 irqEn,
  input  logic [$clog2(TX_DEPTH+1)-1:0]     txCount,
  input  logic [$clog2(RX_DEPTH+1)-1:0]     rxCount,
  output fifo_strobe_t                      strobe,
  output logic [FLAG_W-1:0]                 flags,
  output logic                              irq,
  output logic                              txDmaReq,
  output logic                              rxDmaReq
);
  localparam int TCW = $clog2(TX_DEPTH+1);
  localparam int RCW = $clog2(RX_DEPTH+1);
  localparam logic [TCW:0]   TX_LIM  = (TCW+1)'(TX_DEPTH);
  localparam logic [RCW-1:0] RX_FULL = RCW'(RX_DEPTH);

  logic [2:0] busN;
  logic txFits, rxHas, rxIsFull, txIsEmpty;
  logic txPopReq, rxPushReq;
  logic txBelow, rxAbove;
  logic [FLAG_W-1:0] setVec, clrMask, keepMask, flagsNext;

  assign busN      = sizeToBytes(busSize);
  assign txFits    = ({1'b0, txCount} + (TCW+1)'(busN)) <= TX_LIM;
  assign rxHas     = rxCount >= RCW'(busN);
  assign rxIsFull  = (rxCount == RX_FULL);
  assign txIsEmpty = (txCount == '0);
  assign txPopReq  = shTxPop & txEn;
  assign rxPushReq = shRxPush & rxEn;
  assign txBelow   = txCount < txLevel;
  assign rxAbove   = rxCount > rxLevel;

  // legal moves only; a clear cancels any move in the same cycle
  always_comb begin
    strobe         = '0;
    strobe.txClr   = txClr;
    strobe.rxClr   = rxClr;
    strobe.txPushN = (busWrEn && txFits && !txClr) ? busN : 3'd0;
    strobe.txPop   = txPopReq && !txIsEmpty && !txClr;
    strobe.rxPush  = rxPushReq && !rxIsFull && !rxClr;
    strobe.rxPopN  = (busRdEn && rxHas && !rxClr) ? busN : 3'd0;
  end

  always_comb begin
    setVec             = '0;
    setVec[F_TX_THR]   = txBelow;
    setVec[F_TX_EMPTY] = txIsEmpty;
    setVec[F_RX_THR]   = rxAbove;
    setVec[F_RX_FULL]  = rxIsFull;
    setVec[F_TX_OVR]   = busWrEn && !txFits;
    setVec[F_TX_UND]   = txPopReq && txIsEmpty;
    setVec[F_RX_OVR]   = rxPushReq && rxIsFull;
    setVec[F_RX_UND]   = busRdEn && !rxHas;
    clrMask  = flagClr | (txClr ? TX_FLAG_MASK : '0) | (rxClr ? RX_FLAG_MASK : '0);
    keepMask = flags & ~clrMask;
    flagsNext = keepMask | (setVec & ~((txClr ? TX_FLAG_MASK : '0) | (rxClr ? RX_FLAG_MASK : '0)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flagsNext;
      irq   <= |(flags & irqEn);
    end
  end

  assign txDmaReq = txDmaEn & txBelow;
  assign rxDmaReq = rxDmaEn & rxAbove;

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (keepMask != '0) |=> ((flags & $past(keepMask)) == $past(keepMask)));

  a_r10_rx_underrun: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && (rxCount < RCW'(busN)) && !rxClr) |=> flags[F_RX_UND]);

  a_r9_rx_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (shRxPush && rxEn && (rxCount == RX_FULL) && !rxClr) |=> flags[F_RX_OVR]);

  a_r7_tx_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !txClr && (strobe.txPushN == 3'd0)) |=> flags[F_TX_OVR]);

endmodule

// File: rtl/byte_fifo_pair.sv
module byte_fifo_pair
  import fifo_pair_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busWrEn,
  input  logic                              busRdEn,
  input  logic [1:0]                        busSize,
  input  logic [31:0]                       busWrData,
  output logic [31:0]                       busRdData,
  input  logic                              shTxPop,
  output logic [7:0]                        shTxData,
  input  logic                              shRxPush,
  input  logic [7:0]                        shRxData,
  input  logic                              txEn,
  input  logic                              rxEn,
  input  logic                              txClr,
  input  logic                              rxClr,
  input  logic [$clog2(TX_DEPTH+1)-1:0]     txLevel,
  input  logic [$clog2(RX_DEPTH+1)-1:0]     rxLevel,
  input  logic                              txDmaEn,
  input  logic                              rxDmaEn,
  output logic                              txDmaReq,
  output logic                              rxDmaReq,
  output logic [$clog2(TX_DEPTH+1)-1:0]     txCount,
  output logic [$clog2(RX_DEPTH+1)-1:0]     rxCount,
  input  logic [7:0]                        flagClr,
  input  logic [7:0]                        irqEn,
  output logic [7:0]                        flags,
  output logic                              irq
);
  fifo_strobe_t strobe;

  fifo_pair_ctrl #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .busSize  (busSize),
    .shTxPop  (shTxPop),
    .shRxPush (shRxPush),
    .txEn     (txEn),
    .rxEn     (rxEn),
    .txClr    (txClr),
    .rxClr    (rxClr),
    .txLevel  (txLevel),
    .rxLevel  (rxLevel),
    .txDmaEn  (txDmaEn),
    .rxDmaEn  (rxDmaEn),
    .flagClr  (flagClr),
    .irqEn    (irqEn),
    .txCount  (txCount),
    .rxCount  (rxCount),
    .strobe   (strobe),
    .flags    (flags),
    .irq      (irq),
    .txDmaReq (txDmaReq),
    .rxDmaReq (rxDmaReq)
  );

  fifo_pair_datapath #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .shRxData  (shRxData),
    .busRdData (busRdData),
    .shTxData  (shTxData),
    .txCount   (txCount),
    .rxCount   (rxCount)
  );

endmodule

// File: tb/sim_byte_fifo_pair.sv
module sim_byte_fifo_pair;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 0, busRdEn = 0;
  logic [1:0] busSize = 0;
  logic [31:0] busWrData = 0;
  logic [31:0] busRdData;
  logic shTxPop = 0, shRxPush = 0;
  logic [7:0] shTxData;
  logic [7:0] shRxData = 0;
  logic txEn = 1, rxEn = 1, txClr = 0, rxClr = 0;
  logic [4:0] txLevel = 0;
  logic [5:0] rxLevel = 6'd63;
  logic txDmaEn = 0, rxDmaEn = 0;
  logic txDmaReq, rxDmaReq;
  logic [4:0] txCount;
  logic [5:0] rxCount;
  logic [7:0] flagClr = 0, irqEn = 0;
  logic [7:0] flags;
  logic irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];

  always #5 clk = ~clk;

  byte_fifo_pair u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic int nBytes(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  // driver: scoreboard records bytes expected out of the shifter side
  task automatic busWrite(input logic [1:0] s, input logic [31:0] d, input bit accept);
    @(negedge clk);
    busWrEn = 1; busSize = s; busWrData = d;
    if (accept) for (int i = 0; i < nBytes(s); i++) txQ.push_back(d[8*i +: 8]);
    @(negedge clk);
    busWrEn = 0;
  endtask

  // monitor: compares popped transmit bytes with the scoreboard
  task automatic shPop(input bit expectZero, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    shTxPop = 1;
    #1;
    exp = (expectZero || txQ.size() == 0) ? 8'h00 : txQ.pop_front();
    check(shTxData == exp, tag, {24'h0, shTxData}, {24'h0, exp});
    @(negedge clk);
    shTxPop = 0;
  endtask

  task automatic shPush(input logic [7:0] b, input bit accept);
    @(negedge clk);
    shRxPush = 1; shRxData = b;
    if (accept) rxQ.push_back(b);
    @(negedge clk);
    shRxPush = 0;
  endtask

  task automatic busRead(input logic [1:0] s, input bit expectUnder, input string tag);
    logic [31:0] exp;
    exp = 0;
    @(negedge clk);
    busRdEn = 1; busSize = s;
    #1;
    if (!expectUnder) for (int i = 0; i < nBytes(s); i++) exp[8*i +: 8] = rxQ.pop_front();
    check(busRdData == exp, tag, busRdData, exp);
    @(negedge clk);
    busRdEn = 0;
  endtask

  task automatic pulseFlagClr(input logic [7:0] m);
    @(negedge clk);
    flagClr = m;
    @(negedge clk);
    flagClr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R3 reset state
    check(txCount == 0 && rxCount == 0, "R3 reset counts", {txCount, 3'b0, rxCount}, 0);
    check(flags == 0 && irq == 0, "R13 reset flags/irq", {flags, 7'b0, irq}, 0);
    check(!txDmaReq && !rxDmaReq, "R4 reset dma", {txDmaReq, rxDmaReq}, 0);

    // R4 low-water threshold
    @(negedge clk); txLevel = 5'd4; txDmaEn = 1; #1;
    check(txDmaReq == 1, "R4 below level req", txDmaReq, 1);
    busWrite(2'b10, 32'h44332211, 1);
    check(txCount == 4, "R3 count after word", txCount, 4);
    check(txDmaReq == 0, "R4 at level no req", txDmaReq, 0);
    busWrite(2'b01, 32'hAAAA6655, 1);
    busWrite(2'b00, 32'hBBBBBB77, 1);
    check(txCount == 7, "R3 count after mix", txCount, 7);
    pulseFlagClr(8'hFF); settle();
    check(flags[0] == 0, "R4 no flag above level", flags[0], 0);
    // R1 byte order through scoreboard
    for (int i = 0; i < 7; i++) shPop(0, "R1 tx order");
    settle();
    check(flags[0] == 1 && txDmaReq == 1, "R4 flag and req when empty", {flags[0], txDmaReq}, 2'b11);
    // R6 immediate withdrawal
    @(negedge clk); txDmaEn = 0; #1;
    check(txDmaReq == 0, "R6 tx dma withdrawn", txDmaReq, 0);

    // R8 underrun
    pulseFlagClr(8'hFF);
    shPop(1, "R8 empty pop data zero");
    settle();
    check(flags[5] == 1, "R8 tx underrun flag", flags[5], 1);
    // R11 write-one-to-clear of a single bit
    pulseFlagClr(8'h20); settle();
    check(flags[5] == 0, "R11 w1c clears bit", flags[5], 0);
    check(flags[1] == 1, "R11 empty flag kept", flags[1], 1);

    // R7 overrun on full transmit queue
    txLevel = 0;
    for (int i = 0; i < 4; i++) busWrite(2'b10, 32'h03020100 + 32'h04040404 * i, 1);
    check(txCount == 16, "R3 tx full count", txCount, 16);
    busWrite(2'b00, 32'h99, 0);
    settle();
    check(flags[4] == 1, "R7 tx overrun flag", flags[4], 1);
    check(txCount == 16, "R7 count unchanged", txCount, 16);
    for (int i = 0; i < 16; i++) shPop(0, "R7 contents intact");

    // R5 high-water threshold on exact boundary
    @(negedge clk); rxLevel = 6'd2; rxDmaEn = 1;
    shPush(8'hA0, 1); shPush(8'hA1, 1);
    check(rxDmaReq == 0, "R5 at level no req", rxDmaReq, 0);
    shPush(8'hA2, 1);
    check(rxDmaReq == 1, "R5 above level req", rxDmaReq, 1);
    settle();
    check(flags[2] == 1, "R5 rx threshold flag", flags[2], 1);
    @(negedge clk); rxDmaEn = 0; #1;
    check(rxDmaReq == 0, "R6 rx dma withdrawn", rxDmaReq, 0);
    for (int i = 3; i < 7; i++) shPush(8'hA0 + 8'(i), 1);
    // R2 read widths
    busRead(2'b10, 0, "R2 word read");
    busRead(2'b01, 0, "R2 half read");
    check(rxCount == 1, "R3 rx count", rxCount, 1);
    // R10 underrun leaves contents
    busRead(2'b10, 1, "R10 underrun data zero");
    settle();
    check(flags[7] == 1 && rxCount == 1, "R10 flag and count", {flags[7], 2'b0, rxCount}, 9'h101);
    busRead(2'b00, 0, "R2 byte read after underrun");

    // R9 overrun on full receive queue
    for (int i = 0; i < 32; i++) shPush(8'(8'h40 + i), 1);
    check(rxCount == 32, "R3 rx full count", rxCount, 32);
    shPush(8'hEE, 0);
    settle();
    check(flags[6] == 1 && rxCount == 32, "R9 rx overrun", {flags[6], 2'b0, rxCount}, 9'h120);
    check(flags[3] == 1, "R11 rx full flag", flags[3], 1);

    // R12 per-queue clear
    @(negedge clk); rxClr = 1;
    @(negedge clk); rxClr = 0;
    rxQ.delete();
    settle();
    check(rxCount == 0, "R12 rx count cleared", rxCount, 0);
    check((flags & 8'hCC) == 0, "R12 rx flags cleared", flags & 8'hCC, 0);
    check(flags[4] == 1, "R12 tx flags kept", flags[4], 1);

    // R13 masked interrupt
    pulseFlagClr(8'hFF);
    @(negedge clk); irqEn = 8'h80;
    settle();
    check(irq == 0, "R13 masked flags no irq", irq, 0);
    busRead(2'b00, 1, "R10 empty byte read");
    settle();
    check(irq == 1, "R13 enabled flag irq", irq, 1);

    // R14 shifter-side disables
    @(negedge clk); rxEn = 0;
    shPush(8'h55, 0);
    check(rxCount == 0, "R14 rx push ignored", rxCount, 0);
    @(negedge clk); txEn = 0;
    busWrite(2'b00, 32'h12, 1);
    pulseFlagClr(8'hFF);
    shPop(1, "R14 disabled pop zero");
    check(txCount == 1, "R14 tx pop ignored", txCount, 1);
    settle();
    check(flags[5] == 0, "R14 no underrun when off", flags[5], 0);
    @(negedge clk); txEn = 1;
    shPop(0, "R14 data after enable");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule